// File: doc/BRIEF.md
# Programmable Timer/Event Counter Unit

This block is an 8-bit up-counter with three ways of advancing. It can count edges on an external input pin, count ticks from a divided system clock, or measure how long the pin stays at one level by counting divided-clock ticks between two opposite edges. A single 8-bit control byte chooses the way of counting, which edge of the pin is active, run or stop, and the divide ratio. A separate preload byte supplies the reload value.

When the counter steps past its all-ones value it reloads from the preload byte and raises a one-cycle overflow strobe. Each overflow also toggles a frequency output while the unit is running, so a square wave at a rate set by the preload appears there. The prescaler's free-running divider chain is brought out as a port so that neighbouring logic, such as a PWM stage, can use it as a counter.

The external pin is asynchronous and is resynchronised inside the block. In pulse-measure mode the unit stops itself when the measured pulse ends, which lets software read a stable width.

Top module: `tmr_unit`

## Requirements
- R1: With divide select n in control bits [2:0] and timer mode, the counter advances once every 2^n system clocks, so the spacing between consecutive overflows is (256 - preload) * 2^n cycles. Select 0 means every clock and select 7 means every 128 clocks.
- R2: In event mode (control bits [7:6] = 01) the counter advances once per active edge of the pin. Control bit 3 = 0 makes the rising edge active and bit 3 = 1 makes the falling edge active. The inactive edge has no effect.
- R3: With control bit 4 = 0 the counter holds its value whatever the pin and the prescaler do.
- R4: Control bit 5 always reads back as 0. Every other control bit reads back as written.
- R5: With control bits [7:6] = 00 the counter holds its value even while bit 4 is 1.
- R6: In timer mode (bits [7:6] = 10) with select 0 and bit 4 = 1, the counter advances by one on every clock edge after the edge that stores the control write.
- R7: When the counter steps from 255 it loads the preload value in place of 256, and the overflow output is 1 for the following cycle.
- R8: A preload write while bit 4 = 0 also loads the counter at the same edge. A preload write while bit 4 = 1 leaves the counter untouched and only affects later reloads.
- R9: The frequency output inverts on each overflow while bit 4 = 1. It is driven to 0 one cycle after bit 4 reads as 0.
- R10: In pulse-measure mode (bits [7:6] = 11) counting at the divided rate begins with the active edge and ends at the opposite edge. A level lasting W clocks adds W at select 0. Hardware then clears bit 4, so later pin activity is ignored.
- R11: The divider chain output increments by one, modulo 128, on every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | External timer input, asynchronous |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| pre_we | input | 1 | Preload byte write strobe |
| pre_wdata | input | 8 | Preload byte write data |
| cnt_q | output | 8 | Current count |
| ovf_pulse | output | 1 | One-cycle overflow strobe |
| fout | output | 1 | Frequency output, toggled by overflow |
| div_tap | output | 7 | Free-running prescaler chain |

## Verification
Any wrong internal state shows up at the count port, usually within a cycle or two. A bad synchroniser or edge selection shifts the count by one per pulse as soon as the pulse has crossed the two flops. A wrong divider tap stretches or shrinks the overflow spacing, which is measured directly as an interval. A measuring flag that gets stuck either keeps counting after the pulse ends or leaves the run bit set in the read-back byte. Both show up within a few clocks of the closing edge. Reload errors appear on the first overflow as a wrong count value next to the overflow strobe.

// File: rtl/tmr_pkg.sv
// Shared definitions for the timer/event counter unit.
// Assumes the control byte layout below is fixed by software convention.
package tmr_pkg;
    typedef enum logic [1:0] {
        MD_IDLE  = 2'b00,
        MD_EVENT = 2'b01,
        MD_TIMER = 2'b10,
        MD_PULSE = 2'b11
    } tmr_mode_e;

    localparam int CTL_EDGE_BIT = 3;
    localparam int CTL_RUN_BIT  = 4;
    localparam int CTL_PAD_BIT  = 5;
    localparam int CTL_MODE_LO  = 6;
endpackage

// File: rtl/tmr_prescaler.sv
// Free-running divider chain with a power-of-two tick select.
// tick is high one clock in every 2^sel; sel = 0 gives a tick every clock.
// Assumes the chain width is 2^SEL_W - 1 so the largest select fits.
module tmr_prescaler #(
    parameter int SEL_W = 3,
    localparam int DIV_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick,
    output logic [DIV_W-1:0] chain
);
    logic [DIV_W-1:0] mask;

    // Divider chain: counts every clock from reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= chain + 1'b1;
    end

    // Low-bit mask of the chain bits that must all be one for a tick.
    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (i < 32'(sel));
    end

    // Tick when every selected low chain bit is set.
    always_comb tick = &(chain | ~mask);
endmodule

// File: rtl/tmr_edge_sync.sv
// Two-flop synchroniser plus edge detector for the external pin.
// act is the selected active edge, opp is the opposite one; both last one clock.
// Assumes the pin is held for at least two clocks per level.
module tmr_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic act,
    output logic opp
);
    logic [2:0] sh;
    logic       rise, fall;

    // Synchroniser and one-clock history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], pin};
    end

    // Edge decode and active-edge selection.
    always_comb begin
        rise = sh[1] & ~sh[2];
        fall = ~sh[1] & sh[2];
        act  = fall_sel ? fall : rise;
        opp  = fall_sel ? rise : fall;
    end
endmodule

// File: rtl/tmr_regs.sv
// Control and preload byte storage.
// A control write always wins over the hardware stop request from the counter.
// The pad bit is stored as zero.
module tmr_regs #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             pre_we,
    input  logic [CNT_W-1:0] pre_wdata,
    input  logic             hw_stop,
    output logic [7:0]       ctl_q,
    output logic [CNT_W-1:0] pre_q
);
    import tmr_pkg::*;

    localparam logic [7:0] PAD_MASK = 8'(1 << CTL_PAD_BIT);

    // Control byte: software write, else hardware clear of the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctl_q <= '0;
        else if (ctl_we)  ctl_q <= ctl_wdata & ~PAD_MASK;
        else if (hw_stop) ctl_q[CTL_RUN_BIT] <= 1'b0;
    end

    // Preload byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_we) pre_q <= pre_wdata;
    end
endmodule

// File: rtl/tmr_counter.sv
// Up-counter with reload, overflow strobe, frequency output and pulse-measure control.
// Assumes tick and the edge strobes are single-cycle and synchronous to clk.
module tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tmr_pkg::tmr_mode_e mode,
    input  logic               run,
    input  logic               tick,
    input  logic               act,
    input  logic               opp,
    input  logic               pre_we,
    input  logic [CNT_W-1:0]   pre_wdata,
    input  logic [CNT_W-1:0]   pre_q,
    output logic [CNT_W-1:0]   cnt,
    output logic               ovf,
    output logic               fout,
    output logic               hw_stop
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic meas;
    logic inc;
    logic wrap;
    logic pulse_on;

    // Advance decision for each mode.
    always_comb begin
        pulse_on = run && (mode == MD_PULSE);
        case (mode)
            MD_EVENT: inc = run && act;
            MD_TIMER: inc = run && tick;
            MD_PULSE: inc = pulse_on && tick && ((meas && !opp) || (!meas && act));
            default:  inc = 1'b0;
        endcase
        wrap    = inc && (cnt == CNT_MAX);
        hw_stop = pulse_on && meas && opp;
    end

    // Measuring flag for pulse-measure mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !pulse_on) meas <= 1'b0;
        else if (!meas && act)   meas <= 1'b1;
        else if (meas && opp)    meas <= 1'b0;
    end

    // Count register: direct load when stopped, reload on wrap, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (pre_we && !run) cnt <= pre_wdata;
        else if (wrap)           cnt <= pre_q;
        else if (inc)            cnt <= cnt + 1'b1;
    end

    // Overflow strobe and frequency output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf  <= 1'b0;
            fout <= 1'b0;
        end else begin
            ovf  <= wrap;
            fout <= run ? (fout ^ wrap) : 1'b0;
        end
    end
endmodule

// File: rtl/tmr_unit.sv
// Timer/event counter top: control byte, preload, prescaler, pin sync and counter.
// Assumes the pin is asynchronous and the write strobes are synchronous to clk.
module tmr_unit #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3,
    localparam int DIV_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_rdata,
    input  logic             pre_we,
    input  logic [CNT_W-1:0] pre_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_pulse,
    output logic             fout,
    output logic [DIV_W-1:0] div_tap
);
    import tmr_pkg::*;

    logic [7:0]       ctl_q;
    logic [CNT_W-1:0] pre_q;
    logic             hw_stop;
    logic             tick, act, opp;
    tmr_mode_e        mode;

    assign mode      = tmr_mode_e'(ctl_q[CTL_MODE_LO +: 2]);
    assign ctl_rdata = ctl_q;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .pre_we(pre_we), .pre_wdata(pre_wdata),
        .hw_stop(hw_stop), .ctl_q(ctl_q), .pre_q(pre_q)
    );

    tmr_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk(clk), .rst_n(rst_n),
        .sel(ctl_q[SEL_W-1:0]), .tick(tick), .chain(div_tap)
    );

    tmr_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin_in),
        .fall_sel(ctl_q[CTL_EDGE_BIT]), .act(act), .opp(opp)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .mode(mode), .run(ctl_q[CTL_RUN_BIT]),
        .tick(tick), .act(act), .opp(opp),
        .pre_we(pre_we), .pre_wdata(pre_wdata), .pre_q(pre_q),
        .cnt(cnt_q), .ovf(ovf_pulse), .fout(fout), .hw_stop(hw_stop)
    );
endmodule

// File: rtl/tmr_unit_chk.sv
// Property checker for tmr_unit, attached by bind.
module tmr_unit_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctl_rdata,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_pulse,
    input logic             fout,
    input logic             pre_we,
    input logic [CNT_W-1:0] pre_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[5] == 1'b0);

    assert_fout_low_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[4] |=> !fout);

    assert_reload_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> cnt_q == $past(pre_q));

    assert_wrap_from_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $past(cnt_q) == CNT_MAX);

    // R3 and R5: a stopped or idle counter changes only through a preload write
    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ctl_rdata[4] || ctl_rdata[7:6] == 2'b00) && !pre_we) |=> $stable(cnt_q));
endmodule

bind tmr_unit tmr_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .cnt_q(cnt_q),
    .ovf_pulse(ovf_pulse), .fout(fout), .pre_we(pre_we), .pre_q(pre_q)
);

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       pre_we = 1'b0;
    logic [7:0] pre_wdata = '0;
    logic [7:0] cnt_q;
    logic       ovf_pulse;
    logic       fout;
    logic [6:0] div_tap;

    tmr_unit dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .pre_we(pre_we), .pre_wdata(pre_wdata),
        .cnt_q(cnt_q), .ovf_pulse(ovf_pulse), .fout(fout), .div_tap(div_tap)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        int    id;
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    int compared = 0;
    int mismatched = 0;
    int ovf_seen = 0;
    int cyc = 0;
    int last_iv = 0;
    int tap_delta = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rst_n && ovf_pulse) ovf_seen <= ovf_seen + 1;

    function automatic int observe(input int id);
        case (id)
            0: return int'(cnt_q);
            1: return int'(ctl_rdata);
            2: return int'(fout);
            3: return ovf_seen;
            4: return last_iv;
            5: return int'(ovf_pulse);
            default: return tap_delta;
        endcase
    endfunction

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            item_t it;
            int act;
            wait (q.size() != 0);
            #1;
            it = q.pop_front();
            act = observe(it.id);
            compared++;
            if (act != it.exp) begin
                mismatched++;
                $display("FAIL %s item %0d: actual=0x%0h expected=0x%0h", it.req, it.id, act, it.exp);
            end
        end
    end

    task automatic expect_item(input int id, input int exp, input string req);
        item_t it;
        it.id = id; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_pre(input logic [7:0] v);
        pre_we = 1'b1; pre_wdata = v;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic pulse_pin();
        pin_in = 1'b1;
        repeat (3) @(negedge clk);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_ovf();
        do @(negedge clk); while (!ovf_pulse);
    endtask

    task automatic interval(input int sel);
        int t1;
        wr_pre(8'hF0);
        wr_ctl(8'h90 | 8'(sel));
        wait_ovf();
        t1 = cyc;
        wait_ovf();
        last_iv = cyc - t1;
        expect_item(4, 16 << sel, "R1");
        @(negedge clk);
        wr_ctl(8'h80);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog (all): actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_item(0, 0, "reset");
        expect_item(1, 0, "reset");
        expect_item(2, 0, "reset");
        expect_item(5, 0, "reset");
        // R11: divider chain advances by one per clock
        t0 = int'(div_tap);
        @(negedge clk);
        tap_delta = (int'(div_tap) - t0) & 127;
        expect_item(6, 1, "R11");

        // R4: pad bit reads zero, others as written
        wr_ctl(8'hFF);
        expect_item(1, 8'hDF, "R4");
        wr_ctl(8'h00);
        // R8: preload while stopped loads counter
        wr_pre(8'hFE);
        expect_item(0, 8'hFE, "R8");

        // R5: idle mode with run set does not count
        wr_ctl(8'h10);
        repeat (20) @(negedge clk);
        expect_item(0, 8'hFE, "R5");

        // R2: event mode, rising edge
        wr_ctl(8'h50);
        pulse_pin();
        expect_item(0, 8'hFF, "R2");
        pulse_pin();
        expect_item(0, 8'hFE, "R7");
        expect_item(3, 1, "R7");
        expect_item(2, 1, "R9");

        // R2: falling edge select, rising edge ignored
        wr_ctl(8'h58);
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        expect_item(0, 8'hFE, "R2");
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
        expect_item(0, 8'hFF, "R2");

        // R3 and R9: stop, output forced low, pulses ignored
        wr_ctl(8'h48);
        @(negedge clk);
        expect_item(2, 0, "R9");
        pulse_pin();
        expect_item(0, 8'hFF, "R3");

        // R8: preload while running does not touch count
        wr_ctl(8'h58);
        wr_pre(8'h10);
        expect_item(0, 8'hFF, "R8");
        pulse_pin();
        expect_item(0, 8'h10, "R7");
        expect_item(3, 2, "R7");
        expect_item(2, 1, "R9");

        // R6: timer mode, select 0
        wr_ctl(8'h80);
        wr_pre(8'h20);
        wr_ctl(8'h90);
        expect_item(0, 8'h20, "R6");
        repeat (5) @(negedge clk);
        expect_item(0, 8'h25, "R6");
        wr_ctl(8'h80);
        repeat (5) @(negedge clk);
        expect_item(0, 8'h26, "R3");

        // R1: overflow spacing for several divide selects
        interval(0);
        interval(2);
        interval(5);

        // R10: pulse-width measurement, rising active
        wr_pre(8'h00);
        wr_ctl(8'hD0);
        pin_in = 1'b1;
        repeat (9) @(negedge clk);
        pin_in = 1'b0;
        repeat (5) @(negedge clk);
        expect_item(0, 9, "R10");
        expect_item(1, 8'hC0, "R10");
        pulse_pin();
        expect_item(0, 9, "R10");

        wait (q.size() == 0);
        #5;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule